// File: doc/BRIEF.md
# UART Oversampling Baud Generator

This block turns the system clock into the 16x oversampling strobe that an asynchronous serial port uses, and into a bit-rate strobe derived from it. A clock-enable stage feeds a 13-bit down-counter that reloads itself. That enable stage works in one of two modes. In the first it is a fixed prescaler that divides by 2 or by 3. In the second it is a 9-bit phase accumulator, which gives a fractional rate.

Software controls the block through a small register port with three write strobes. The control strobe sets the run, fractional-mode and divide-by-3 bits. The fraction strobe sets the 9-bit fraction value. The reload strobe sets the 13-bit reload value. The stored run bit and the stored reload value can be read back. The expected sequence is to stop the generator, write the new settings, and then start it again. Reload writes that arrive while the generator runs are discarded.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both ticks are low, `rd_run` is 0 and `rd_reload` is 0. The prescaler select, the fractional-enable bit and the fraction value also reset to 0.
- R2: In integer mode with `ctl_pre3`=0, `os_tick` is a one-cycle pulse that repeats every 2*(reload+1) clocks.
- R3: In integer mode with `ctl_pre3`=1, `os_tick` repeats every 3*(reload+1) clocks.
- R4: In fractional mode a 9-bit accumulator adds the fraction value F every clock, and each carry out of bit 8 is one counter enable. Over 512*k clocks this gives F*k enables and F*k/(reload+1) ticks. F=0 behaves as F=512, so an enable occurs on every clock.
- R5: A reload write is stored only if the run bit is 0 when the write occurs. If the run bit is 1, the write is discarded and `rd_reload` keeps its previous value.
- R6: After a control write clears the run bit, `os_tick` and `bit_tick` stay low from the second cycle on. Only an event that was already pending can still appear, and only in the first cycle.
- R7: A control write that sets run restarts all divider state. The first `os_tick` appears (reload+1)*P clocks after the edge that stores run, where P is 2 or 3 in integer mode and 1 in fractional mode with F=0.
- R8: `bit_tick` rises together with every 16th `os_tick` and is otherwise low. Its period is 16 oversample periods.
- R9: The end values of the reload range work. Reload 0 gives a tick on every enable, and reload 8191 gives a first tick after 8192 enables.
- R10: In fractional mode the divide-by-3 select has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_run | input | 1 | Run bit value to write |
| ctl_frac_en | input | 1 | Fractional-mode bit value to write |
| ctl_pre3 | input | 1 | Prescaler select to write (0 = /2, 1 = /3) |
| frac_we | input | 1 | Write strobe for the fraction value |
| frac_val | input | 9 | Fraction value to write (0 means 512) |
| rld_we | input | 1 | Write strobe for the reload value |
| rld_val | input | 13 | Reload value to write |
| os_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-rate strobe |
| rd_run | output | 1 | Stored run bit |
| rd_reload | output | 13 | Stored reload value |

## Verification
The hardest case to reach is the largest reload value, 8191, with the divide-by-3 prescaler. Its first tick only arrives about 24,600 clocks after start. The bench programs it directly and waits for that first tick. The exact fractional count is also hard to bring out from the ports. The bench picks F=200 and a window of 2560 clocks, after which the accumulator is back at zero, and so it can expect exactly 500 ticks. Discarded reload writes are driven while the generator runs, and the bench then compares both the readback and the tick spacing.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned RLD_W      = 13;
  localparam int unsigned FRAC_W     = 9;
  localparam int unsigned OS_PER_BIT = 16;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
  parameter int unsigned RLD_W  = 13,
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_run,
  input  logic              ctl_frac_en,
  input  logic              ctl_pre3,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic              rld_we,
  input  logic [RLD_W-1:0]  rld_val,
  output logic              run_q,
  output logic              frac_en_q,
  output logic              pre3_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [RLD_W-1:0]  reload_q
);
  logic              run_d, frac_en_d, pre3_d;
  logic [FRAC_W-1:0] frac_d;
  logic [RLD_W-1:0]  reload_d;

  always_comb begin
    run_d     = run_q;
    frac_en_d = frac_en_q;
    pre3_d    = pre3_q;
    frac_d    = frac_q;
    reload_d  = reload_q;
    if (ctl_we) begin
      run_d     = ctl_run;
      frac_en_d = ctl_frac_en;
      pre3_d    = ctl_pre3;
    end
    if (frac_we) frac_d = frac_val;
    // reload is write-protected while the generator runs
    if (rld_we && !run_q) reload_d = rld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      frac_en_q <= 1'b0;
      pre3_q    <= 1'b0;
      frac_q    <= '0;
      reload_q  <= '0;
    end else begin
      run_q     <= run_d;
      frac_en_q <= frac_en_d;
      pre3_q    <= pre3_d;
      frac_q    <= frac_d;
      reload_q  <= reload_d;
    end
  end

  // R5: a reload write during run leaves the stored value untouched
  a_r5_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && rld_we) |=> $stable(reload_q));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frac_en,
  input  logic              pre3,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              pe
);
  localparam int unsigned          ACC_W = FRAC_W + 1;
  localparam logic [ACC_W-1:0]     FULL  = ACC_W'(1) << FRAC_W;

  logic [1:0]        pcnt_q, pcnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0]  step, sum;
  logic              int_pe;

  always_comb begin
    step   = (frac_val == '0) ? FULL : {1'b0, frac_val};
    sum    = {1'b0, acc_q} + step;
    int_pe = (pcnt_q >= (pre3 ? 2'd2 : 2'd1));
    pe     = 1'b0;
    pcnt_d = '0;
    acc_d  = '0;
    if (run) begin
      if (frac_en) begin
        pe    = sum[FRAC_W];
        acc_d = sum[FRAC_W-1:0];
      end else begin
        pe     = int_pe;
        pcnt_d = int_pe ? 2'd0 : pcnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      acc_q  <= acc_d;
    end
  end

  // R2: integer prescaling never yields enables on back-to-back cycles
  a_r2_int_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frac_en && pe) |=> (!pe || frac_en));
  // R4: a zero fraction value passes every clock through
  a_r4_frac_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frac_en && frac_val == '0) |-> pe);
endmodule

// File: rtl/baud_reload_counter.sv
module baud_reload_counter #(
  parameter int unsigned RLD_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pe,
  input  logic [RLD_W-1:0] reload,
  output logic             os_evt
);
  logic [RLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    os_evt = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_d = reload;
    end else if (pe) begin
      if (cnt_q == '0) begin
        os_evt = 1'b1;
        cnt_d  = reload;
      end else begin
        cnt_d = cnt_q - RLD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: an event requires an enable in the same cycle
  a_r9_evt_needs_pe: assert property (@(posedge clk) disable iff (!rst_n)
    os_evt |-> (pe && run));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned P_RLD_W      = RLD_W,
  parameter int unsigned P_FRAC_W     = FRAC_W,
  parameter int unsigned P_OS_PER_BIT = OS_PER_BIT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic                ctl_run,
  input  logic                ctl_frac_en,
  input  logic                ctl_pre3,
  input  logic                frac_we,
  input  logic [P_FRAC_W-1:0] frac_val,
  input  logic                rld_we,
  input  logic [P_RLD_W-1:0]  rld_val,
  output logic                os_tick,
  output logic                bit_tick,
  output logic                rd_run,
  output logic [P_RLD_W-1:0]  rd_reload
);
  localparam int unsigned      SUB_W    = $clog2(P_OS_PER_BIT);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(P_OS_PER_BIT - 1);

  logic                run_q, frac_en_q, pre3_q, pe, os_evt;
  logic [P_FRAC_W-1:0] frac_q;
  logic [P_RLD_W-1:0]  reload_q;
  logic [SUB_W-1:0]    sub_q, sub_d;
  logic                os_d, bit_d;

  baud_cfg_regs #(.RLD_W(P_RLD_W), .FRAC_W(P_FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_frac_en(ctl_frac_en), .ctl_pre3(ctl_pre3), .frac_we(frac_we),
    .frac_val(frac_val), .rld_we(rld_we), .rld_val(rld_val),
    .run_q(run_q), .frac_en_q(frac_en_q), .pre3_q(pre3_q),
    .frac_q(frac_q), .reload_q(reload_q));

  baud_prescaler #(.FRAC_W(P_FRAC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .frac_en(frac_en_q),
    .pre3(pre3_q), .frac_val(frac_q), .pe(pe));

  baud_reload_counter #(.RLD_W(P_RLD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .pe(pe),
    .reload(reload_q), .os_evt(os_evt));

  always_comb begin
    sub_d = sub_q;
    bit_d = 1'b0;
    os_d  = os_evt;
    if (!run_q) begin
      sub_d = '0;
    end else if (os_evt) begin
      bit_d = (sub_q == SUB_LAST);
      sub_d = sub_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q    <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      sub_q    <= sub_d;
      os_tick  <= os_d;
      bit_tick <= bit_d;
    end
  end

  assign rd_run    = run_q;
  assign rd_reload = reload_q;

  // R6: once the stored run bit is low, the next cycle carries no tick
  a_r6_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!os_tick && !bit_tick));
  // R8: the bit strobe only ever coincides with an oversample strobe
  a_r8_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
endmodule

// File: tb/uart_baud_gen_bench.sv
module uart_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_run = 1'b0, ctl_frac_en = 1'b0, ctl_pre3 = 1'b0;
  logic        frac_we = 1'b0, rld_we = 1'b0;
  logic [8:0]  frac_val = '0;
  logic [12:0] rld_val = '0;
  logic        os_tick, bit_tick, rd_run;
  logic [12:0] rd_reload;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_baud_gen u_uart_baud_gen (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_frac_en(ctl_frac_en), .ctl_pre3(ctl_pre3), .frac_we(frac_we),
    .frac_val(frac_val), .rld_we(rld_we), .rld_val(rld_val),
    .os_tick(os_tick), .bit_tick(bit_tick), .rd_run(rd_run),
    .rd_reload(rd_reload));

  // behavioural reference state
  int m_run, m_fen, m_p3, m_fdv, m_rld;
  int m_pc, m_acc, m_cnt, m_sub, m_os, m_bt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_fen = 0; m_p3 = 0; m_fdv = 0; m_rld = 0;
      m_pc = 0; m_acc = 0; m_cnt = 0; m_sub = 0; m_os = 0; m_bt = 0;
    end else begin
      int en, ev, bt, n_pc, n_acc, n_cnt, n_sub, s;
      en = 0; ev = 0; bt = 0; n_pc = 0; n_acc = 0; n_cnt = m_rld; n_sub = 0;
      if (m_run != 0) begin
        n_cnt = m_cnt; n_sub = m_sub;
        if (m_fen != 0) begin
          s = m_acc + ((m_fdv == 0) ? 512 : m_fdv);
          en = (s >= 512); n_acc = s % 512;
        end else begin
          en = (m_pc >= ((m_p3 != 0) ? 2 : 1));
          n_pc = en ? 0 : m_pc + 1;
        end
        if (en != 0) begin
          if (m_cnt == 0) begin ev = 1; n_cnt = m_rld; end
          else n_cnt = m_cnt - 1;
        end
        if (ev != 0) begin bt = (m_sub == 15); n_sub = (m_sub + 1) % 16; end
      end
      if (rld_we && m_run == 0) m_rld = int'(rld_val);
      if (ctl_we) begin m_run = int'(ctl_run); m_fen = int'(ctl_frac_en); m_p3 = int'(ctl_pre3); end
      if (frac_we) m_fdv = int'(frac_val);
      m_pc = n_pc; m_acc = n_acc; m_cnt = n_cnt; m_sub = n_sub; m_os = ev; m_bt = bt;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "os_tick vs model", int'(os_tick), m_os);
      check(cur_req, "bit_tick vs model", int'(bit_tick), m_bt);
      check(cur_req, "rd_reload vs model", int'(rd_reload), m_rld);
      check(cur_req, "rd_run vs model", int'(rd_run), m_run);
    end
  end

  task automatic wr_ctl(bit run, bit fen, bit p3);
    ctl_run = run; ctl_frac_en = fen; ctl_pre3 = p3; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_rld(int v);
    rld_val = 13'(v); rld_we = 1'b1;
    @(negedge clk); rld_we = 1'b0;
  endtask
  task automatic wr_frac(int v);
    frac_val = 9'(v); frac_we = 1'b1;
    @(negedge clk); frac_we = 1'b0;
  endtask
  // set run and return the cycle index of the first os_tick
  task automatic start_measure(bit fen, bit p3, output int j);
    ctl_run = 1'b1; ctl_frac_en = fen; ctl_pre3 = p3; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
    j = 0;
    while (!os_tick && j < 30000) begin @(negedge clk); j++; end
  endtask
  task automatic stop_gen();
    wr_ctl(1'b0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    int j, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "os_tick at reset", int'(os_tick), 0);
    check("R1", "bit_tick at reset", int'(bit_tick), 0);
    check("R1", "rd_run at reset", int'(rd_run), 0);
    check("R1", "rd_reload at reset", int'(rd_reload), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 and R7: /2 with reload 4
    cur_req = "R2";
    wr_ctl(1'b0, 1'b0, 1'b0); wr_rld(4);
    start_measure(1'b0, 1'b0, j);
    check("R7", "first tick /2 reload 4", j, 10);
    @(negedge clk); j = 1;
    while (!os_tick && j < 100) begin @(negedge clk); j++; end
    check("R2", "period /2 reload 4", j, 10);
    repeat (150) @(negedge clk);

    // R5: write during run ignored
    cur_req = "R5";
    wr_rld(9);
    @(negedge clk);
    check("R5", "reload held during run", int'(rd_reload), 4);
    repeat (40) @(negedge clk);

    // R6: stop
    cur_req = "R6";
    wr_ctl(1'b0, 1'b0, 1'b0);
    cnt = 0;
    repeat (20) begin @(negedge clk); cnt += int'(os_tick) + int'(bit_tick); end
    check("R6", "ticks after stop", cnt, 0);

    // R5 accepted while stopped, R3 /3
    cur_req = "R3";
    wr_rld(2);
    check("R5", "reload written while stopped", int'(rd_reload), 2);
    start_measure(1'b0, 1'b1, j);
    check("R7", "first tick /3 reload 2", j, 9);
    @(negedge clk); j = 1;
    while (!os_tick && j < 100) begin @(negedge clk); j++; end
    check("R3", "period /3 reload 2", j, 9);
    repeat (200) @(negedge clk);
    stop_gen();

    // R9 reload 0, R8 bit spacing
    cur_req = "R8";
    wr_rld(0);
    start_measure(1'b0, 1'b0, j);
    check("R9", "first tick /2 reload 0", j, 2);
    while (!bit_tick) @(negedge clk);
    @(negedge clk); j = 1; cnt = 0;
    while (!bit_tick && j < 200) begin cnt += int'(os_tick); @(negedge clk); j++; end
    check("R8", "bit_tick period", j, 32);
    check("R8", "os ticks between bit ticks", cnt, 15);
    repeat (100) @(negedge clk);
    stop_gen();

    // R4 pass-through, R10 pre3 ignored in fractional mode
    cur_req = "R10";
    wr_rld(3); wr_frac(0);
    start_measure(1'b1, 1'b1, j);
    check("R10", "frac F=0 first tick with pre3 set", j, 4);
    @(negedge clk); j = 1;
    while (!os_tick && j < 100) begin @(negedge clk); j++; end
    check("R4", "frac F=0 period", j, 4);
    repeat (100) @(negedge clk);
    stop_gen();

    // R4 fractional count F=200 reload 1
    cur_req = "R4";
    wr_rld(1); wr_frac(200);
    wr_ctl(1'b1, 1'b1, 1'b0);
    cnt = 0;
    for (int k = 0; k <= 2560; k++) begin cnt += int'(os_tick); @(negedge clk); end
    check("R4", "ticks in 2560 clocks F=200", cnt, 500);
    stop_gen();
    wr_frac(511); wr_rld(6);
    wr_ctl(1'b1, 1'b1, 1'b0);
    repeat (3000) @(negedge clk);
    stop_gen();

    // R9 maximum reload with /3
    cur_req = "R9";
    wr_rld(8191);
    start_measure(1'b0, 1'b1, j);
    check("R9", "first tick reload 8191 /3", j, 24576);
    repeat (50) @(negedge clk);
    stop_gen();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule